// File: doc/BRIEF.md
# Single-Access SDRAM Command Sequencer

This block sits between a simple request/acknowledge memory bus and a single-phase DFI-style SDRAM PHY port. It serves one bus access at a time. Every access becomes a short, fixed chain of SDRAM commands, and the block raises a one-cycle acknowledge when that chain is complete. The block remembers a single open row, given as bank plus row. An access to that row is issued at once. Any other access first closes the open row and then activates the new one.

A down-counter asks for a refresh at a fixed interval. The refresh waits until the sequencer is back in its idle state. It takes precedence over a bus access that is waiting in the same cycle. A refresh always closes every bank first, then issues the auto-refresh command, and leaves no row open.

Every command and strobe output is decoded combinationally from the state. Any cycle that issues no command is a NOP, because the row-strobe, column-strobe and write-enable lines default high. Chip select is held low at all times.

Top module: `sdr_single_ctrl`

## Requirements
- R1: `dfi_cs_n_o` is 0 in every cycle. Any cycle without a command drives {ras_n,cas_n,we_n} = 3'b111 (NOP), and this includes the cycles in reset.
- R2: Command codes on {ras_n,cas_n,we_n}: activate 3'b011, read 3'b101, write 3'b100, precharge 3'b010, auto-refresh 3'b001. No other code appears.
- R3: `dfi_wrdata_mask_o` equals the bitwise inverse of `bus_sel_i` in every cycle, and `dfi_wrdata_o` equals `bus_dat_i`. A masked byte keeps its old memory value.
- R4: `dfi_rddata_en_o` is high only in read-command cycles and `dfi_wrdata_en_o` only in write-command cycles. The two are never high together.
- R5: Bus address layout is {bank, row, column}, with the column in the low COL_W bits. On read and write, `dfi_addr_o` carries the column and bit 10 is 0 (no auto-precharge). On precharge, bit 10 is 1 (all banks).
- R6: If the open row matches the request's bank and row, the read or write command is issued with no precharge and no activate.
- R7: On a miss with a row open, the block issues a precharge, then an activate exactly T_RP cycles later, then the access exactly T_RCD cycles after the activate. On a miss with no row open, it issues only the activate and then the access. An activate is never issued while a row is open.
- R8: A refresh becomes pending every T_REFI cycles. It is served as a precharge, then an auto-refresh exactly T_RP cycles later. No command follows until T_RFC cycles after the auto-refresh. After a refresh, no row is open.
- R9: If a refresh is pending and a bus access is waiting in the same idle cycle, the refresh is carried out first.
- R10: A read command issued in cycle t captures `dfi_rddata_i` at cycle t+CL. The acknowledge follows in cycle t+CL+1, with that word on `bus_dat_o`.
- R11: A write is acknowledged in the same cycle as its write command.
- R12: `bus_ack_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cyc_i | input | 1 | Access request, held until acknowledged |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | ADDR_W | Word address {bank,row,column} |
| bus_dat_i | input | DATA_W | Write data |
| bus_sel_i | input | DATA_W/8 | Byte enables |
| bus_dat_o | output | DATA_W | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| dfi_cs_n_o | output | 1 | Chip select, held low |
| dfi_ras_n_o | output | 1 | Row strobe |
| dfi_cas_n_o | output | 1 | Column strobe |
| dfi_we_n_o | output | 1 | Write enable |
| dfi_bank_o | output | BA_W | Bank address |
| dfi_addr_o | output | ROW_W | Row / column address |
| dfi_wrdata_en_o | output | 1 | Write data enable |
| dfi_wrdata_o | output | DATA_W | Write data to PHY |
| dfi_wrdata_mask_o | output | DATA_W/8 | Byte mask (1 = masked) |
| dfi_rddata_en_o | output | 1 | Read data enable |
| dfi_rddata_i | input | DATA_W | Read data from PHY |

## Verification
The two functions that can meet in one cycle are a pending refresh and a waiting bus access. Both are seen by the idle state in the same cycle. The bench provokes this by issuing accesses back to back with a short refresh interval. Each new request is raised right after the previous acknowledge, so some refresh requests become pending during an access and collide with the next request. A transaction counts as a collision when both its refresh precharge and its auto-refresh fall inside it. For such a transaction the bench checks three things: the refresh came first, only the activate followed, and the acknowledged data is still correct.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010,
    CMD_REF = 3'b001
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RPRE, S_RPW, S_REF, S_RFW,
    S_MPRE, S_MPW, S_ACT, S_ACW,
    S_WR, S_RD, S_RDW, S_RDA
  } sdr_state_e;

  localparam int AP_BIT = 10;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int T_REFI = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic pend_o
);
  localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(T_REFI - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RELOAD;
      pend_o <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0)  pend_o <= 1'b1;
      else if (done_i)  pend_o <= 1'b0;
    end
  end

  p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !done_i |=> pend_o);
endmodule

// File: rtl/sdr_row_tracker.sv
module sdr_row_tracker #(
  parameter int TAG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             close_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             open_o,
  output logic             hit_o
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      tag_q  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      tag_q  <= tag_i;
    end else if (close_i) begin
      open_o <= 1'b0;
    end
  end

  assign hit_o = open_o && (tag_q == tag_i);

  p_open_after_act_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o);
  p_closed_after_pre_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i && !act_i |=> !open_o);
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int BA_W  = 2,
  parameter int T_RP  = 3,
  parameter int T_RCD = 3,
  parameter int T_RFC = 7,
  parameter int CL    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             ref_pend_i,
  input  logic             row_open_i,
  input  logic             row_hit_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [BA_W-1:0]  bank_i,
  output sdr_cmd_e         cmd_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [BA_W-1:0]  bank_o,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic             ack_o,
  output logic             cap_o,
  output logic             ref_done_o
);
  localparam int WMAX = max4(T_RP, T_RCD, T_RFC, CL);
  localparam int WW   = $clog2(WMAX + 1);

  sdr_state_e     st_q, st_d;
  logic [WW-1:0]  w_q, w_val;
  logic           w_load;
  logic           w_zero;

  assign w_zero = (w_q == '0);

  always_comb begin
    st_d       = st_q;
    cmd_o      = CMD_NOP;
    addr_o     = '0;
    bank_o     = '0;
    rd_en_o    = 1'b0;
    wr_en_o    = 1'b0;
    ack_o      = 1'b0;
    cap_o      = 1'b0;
    ref_done_o = 1'b0;
    w_load     = 1'b0;
    w_val      = '0;
    case (st_q)
      S_IDLE: begin
        if (ref_pend_i)          st_d = S_RPRE;
        else if (req_i) begin
          if (row_hit_i)         st_d = we_i ? S_WR : S_RD;
          else if (row_open_i)   st_d = S_MPRE;
          else                   st_d = S_ACT;
        end
      end
      S_RPRE, S_MPRE: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = 1'b1;
        w_load         = 1'b1;
        w_val          = WW'(T_RP - 2);
        st_d           = (st_q == S_RPRE) ? S_RPW : S_MPW;
      end
      S_RPW: if (w_zero) st_d = S_REF;
      S_MPW: if (w_zero) st_d = S_ACT;
      S_REF: begin
        cmd_o      = CMD_REF;
        ref_done_o = 1'b1;
        w_load     = 1'b1;
        w_val      = WW'(T_RFC - 2);
        st_d       = S_RFW;
      end
      S_RFW: if (w_zero) st_d = S_IDLE;
      S_ACT: begin
        cmd_o  = CMD_ACT;
        addr_o = row_i;
        bank_o = bank_i;
        w_load = 1'b1;
        w_val  = WW'(T_RCD - 2);
        st_d   = S_ACW;
      end
      S_ACW: if (w_zero) st_d = we_i ? S_WR : S_RD;
      S_WR: begin
        cmd_o              = CMD_WR;
        addr_o[COL_W-1:0]  = col_i;
        bank_o             = bank_i;
        wr_en_o            = 1'b1;
        ack_o              = 1'b1;
        st_d               = S_IDLE;
      end
      S_RD: begin
        cmd_o              = CMD_RD;
        addr_o[COL_W-1:0]  = col_i;
        bank_o             = bank_i;
        rd_en_o            = 1'b1;
        w_load             = 1'b1;
        w_val              = WW'(CL - 1);
        st_d               = S_RDW;
      end
      S_RDW: if (w_zero) begin
        cap_o = 1'b1;
        st_d  = S_RDA;
      end
      S_RDA: begin
        ack_o = 1'b1;
        st_d  = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      w_q  <= '0;
    end else begin
      st_q <= st_d;
      if (w_load)       w_q <= w_val;
      else if (!w_zero) w_q <= w_q - 1'b1;
    end
  end

  p_en_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o && wr_en_o));
  p_ack_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ap_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> !addr_o[AP_BIT]);
  p_cap_then_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> ack_o);
endmodule

// File: rtl/sdr_single_ctrl.sv
module sdr_single_ctrl
  import sdr_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int ROW_W  = 12,
  parameter  int COL_W  = 8,
  parameter  int BA_W   = 2,
  parameter  int T_RP   = 3,
  parameter  int T_RCD  = 3,
  parameter  int T_RFC  = 7,
  parameter  int CL     = 3,
  parameter  int T_REFI = 780,
  localparam int SEL_W  = DATA_W / 8,
  localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cyc_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_adr_i,
  input  logic [DATA_W-1:0] bus_dat_i,
  input  logic [SEL_W-1:0]  bus_sel_i,
  output logic [DATA_W-1:0] bus_dat_o,
  output logic              bus_ack_o,
  output logic              dfi_cs_n_o,
  output logic              dfi_ras_n_o,
  output logic              dfi_cas_n_o,
  output logic              dfi_we_n_o,
  output logic [BA_W-1:0]   dfi_bank_o,
  output logic [ROW_W-1:0]  dfi_addr_o,
  output logic              dfi_wrdata_en_o,
  output logic [DATA_W-1:0] dfi_wrdata_o,
  output logic [SEL_W-1:0]  dfi_wrdata_mask_o,
  output logic              dfi_rddata_en_o,
  input  logic [DATA_W-1:0] dfi_rddata_i
);
  localparam int TAG_W = BA_W + ROW_W;
  localparam int GW    = $clog2(T_RP + 1);

  logic [COL_W-1:0] req_col;
  logic [ROW_W-1:0] req_row;
  logic [BA_W-1:0]  req_bank;
  sdr_cmd_e         cmd;
  logic             ref_pend, ref_done, row_open, row_hit, cap;
  logic             is_act, is_pre;

  assign {req_bank, req_row, req_col} = bus_adr_i;
  assign is_act = (cmd == CMD_ACT);
  assign is_pre = (cmd == CMD_PRE);

  sdr_refresh_timer #(.T_REFI(T_REFI)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (ref_done),
    .pend_o (ref_pend)
  );

  sdr_row_tracker #(.TAG_W(TAG_W)) u_rows (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (is_act),
    .close_i (is_pre),
    .tag_i   ({req_bank, req_row}),
    .open_o  (row_open),
    .hit_o   (row_hit)
  );

  sdr_cmd_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .CL(CL)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_cyc_i),
    .we_i       (bus_we_i),
    .ref_pend_i (ref_pend),
    .row_open_i (row_open),
    .row_hit_i  (row_hit),
    .row_i      (req_row),
    .col_i      (req_col),
    .bank_i     (req_bank),
    .cmd_o      (cmd),
    .addr_o     (dfi_addr_o),
    .bank_o     (dfi_bank_o),
    .rd_en_o    (dfi_rddata_en_o),
    .wr_en_o    (dfi_wrdata_en_o),
    .ack_o      (bus_ack_o),
    .cap_o      (cap),
    .ref_done_o (ref_done)
  );

  assign dfi_cs_n_o = 1'b0;
  assign {dfi_ras_n_o, dfi_cas_n_o, dfi_we_n_o} = cmd;
  assign dfi_wrdata_o = bus_dat_i;

  for (genvar b = 0; b < SEL_W; b++) begin : g_mask
    assign dfi_wrdata_mask_o[b] = ~bus_sel_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_dat_o <= '0;
    else if (cap) bus_dat_o <= dfi_rddata_i;
  end

  // cycles since last precharge, saturating
  logic [GW-1:0] pre_gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_gap_q <= GW'(T_RP);
    else if (is_pre)                pre_gap_q <= GW'(1);
    else if (pre_gap_q != GW'(T_RP)) pre_gap_q <= pre_gap_q + 1'b1;
  end

  p_act_closed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !row_open);
  p_act_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> pre_gap_q == GW'(T_RP));
  p_rw_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD || cmd == CMD_WR) |-> row_open);
  p_ref_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |-> !row_open);
  p_wr_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dfi_wrdata_en_o |-> bus_ack_o);
endmodule

// File: tb/sdr_single_ctrl_tb.sv
module sdr_single_ctrl_tb;
  localparam int DATA_W = 32, ROW_W = 12, COL_W = 8, BA_W = 2;
  localparam int T_RP = 3, T_RCD = 3, T_RFC = 7, CL = 3, T_REFI = 150;
  localparam int SEL_W = DATA_W / 8;
  localparam int ADDR_W = BA_W + ROW_W + COL_W;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_cyc = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_adr = '0;
  logic [DATA_W-1:0] bus_dat = '0, dfi_rddata = '0;
  logic [SEL_W-1:0]  bus_sel = '0;
  logic [DATA_W-1:0] bus_dat_o, dfi_wrdata;
  logic bus_ack, cs_n, ras_n, cas_n, we_n, wr_en, rd_en;
  logic [BA_W-1:0] dfi_bank;
  logic [ROW_W-1:0] dfi_addr;
  logic [SEL_W-1:0] dfi_mask;

  always #10 clk = ~clk;

  sdr_single_ctrl #(
    .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .CL(CL), .T_REFI(T_REFI)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_cyc_i(bus_cyc), .bus_we_i(bus_we), .bus_adr_i(bus_adr),
    .bus_dat_i(bus_dat), .bus_sel_i(bus_sel),
    .bus_dat_o(bus_dat_o), .bus_ack_o(bus_ack),
    .dfi_cs_n_o(cs_n), .dfi_ras_n_o(ras_n), .dfi_cas_n_o(cas_n), .dfi_we_n_o(we_n),
    .dfi_bank_o(dfi_bank), .dfi_addr_o(dfi_addr),
    .dfi_wrdata_en_o(wr_en), .dfi_wrdata_o(dfi_wrdata), .dfi_wrdata_mask_o(dfi_mask),
    .dfi_rddata_en_o(rd_en), .dfi_rddata_i(dfi_rddata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- models ----------------
  logic [DATA_W-1:0] sd_mem  [int];
  logic [DATA_W-1:0] exp_mem [int];
  bit exp_open = 1'b0;
  logic [BA_W+ROW_W-1:0] exp_tag = '0;

  function automatic int key(input logic [BA_W-1:0] b, input logic [ROW_W-1:0] r,
                             input logic [COL_W-1:0] c);
    return int'({b, r, c});
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] nw, input logic [SEL_W-1:0] keep_n);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < SEL_W; b++)
      r[b*8 +: 8] = keep_n[b] ? old[b*8 +: 8] : nw[b*8 +: 8];
    return r;
  endfunction

  // ---------------- monitor ----------------
  int cyc_n = 0;
  always @(posedge clk) if (rst_ni) cyc_n <= cyc_n + 1;

  logic [2:0] last_cmd = C_NOP;
  int last_cyc = 0, rd_cyc = -100, ref_k = 0, rd_cnt = 0, col_cnt = 0;
  bit sd_open = 1'b0, last_rd = 1'b0, prev_ack = 1'b0, act_after_ref = 1'b0;
  logic [ROW_W-1:0] sd_row = '0;
  logic [BA_W-1:0] sd_bank = '0;
  logic [DATA_W-1:0] rd_val = '0;
  int n_act = 0, n_pre = 0, n_ref = 0;
  bit pre_then_ref = 1'b0;

  always @(negedge clk) begin
    logic [2:0] c;
    c = {ras_n, cas_n, we_n};
    if (!rst_ni) begin
      chk(c == C_NOP && !bus_ack && !rd_en && !wr_en, "R1 reset NOP", {c, bus_ack, rd_en, wr_en}, {C_NOP, 3'b000});
    end else begin
      chk(cs_n == 1'b0, "R1 cs_n low", cs_n, 0);
      chk(c inside {C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF}, "R2 legal code", c, C_NOP);
      chk(!(rd_en && wr_en), "R4 exclusive enables", {rd_en, wr_en}, 0);
      chk(rd_en == (c == C_RD) && wr_en == (c == C_WR), "R4 enable/cmd", {rd_en, wr_en, c}, 0);
      chk(dfi_mask == ~bus_sel && dfi_wrdata == bus_dat, "R3 mask/data", dfi_mask, ~bus_sel);
      chk(!(bus_ack && prev_ack), "R12 ack pulse", 1, 0);
      prev_ack = bus_ack;

      // read data pipe
      if (rd_cnt > 0) begin
        rd_cnt--;
        dfi_rddata = (rd_cnt == 0) ? rd_val : DATA_W'($urandom);
      end else dfi_rddata = DATA_W'($urandom);

      if (c != C_NOP) begin
        if (last_cmd == C_PRE)
          chk(cyc_n - last_cyc == T_RP, "R7/R8 precharge gap", cyc_n - last_cyc, T_RP);
        if (last_cmd == C_ACT)
          chk(cyc_n - last_cyc == T_RCD, "R7 activate gap", cyc_n - last_cyc, T_RCD);
        if (last_cmd == C_REF)
          chk(cyc_n - last_cyc >= T_RFC, "R8 refresh gap", cyc_n - last_cyc, T_RFC);
      end
      case (c)
        C_PRE: begin
          chk(dfi_addr[10] == 1'b1, "R5 precharge all", dfi_addr[10], 1);
          sd_open = 1'b0; n_pre++;
        end
        C_REF: begin
          chk(last_cmd == C_PRE, "R8 precharge before refresh", last_cmd, C_PRE);
          ref_k++;
          chk(cyc_n >= ref_k*T_REFI + 1 + T_RP && cyc_n <= ref_k*T_REFI + T_RP + 25,
              "R8 refresh interval", cyc_n, ref_k*T_REFI + 1 + T_RP);
          if (n_pre > 0) pre_then_ref = 1'b1;
          n_ref++;
          exp_open = 1'b0;
        end
        C_ACT: begin
          chk(!sd_open, "R7 activate while closed", sd_open, 0);
          chk({dfi_bank, dfi_addr} == bus_adr[ADDR_W-1:COL_W], "R7 activate row/bank",
              {dfi_bank, dfi_addr}, bus_adr[ADDR_W-1:COL_W]);
          sd_open = 1'b1; sd_row = dfi_addr; sd_bank = dfi_bank; n_act++;
          act_after_ref = (n_ref > 0);
        end
        C_RD, C_WR: begin
          chk(dfi_addr[10] == 1'b0 && dfi_addr[COL_W-1:0] == bus_adr[COL_W-1:0],
              "R5 column/no-autoprecharge", dfi_addr, bus_adr[COL_W-1:0]);
          chk(sd_open && {dfi_bank, sd_row} == bus_adr[ADDR_W-1:COL_W], "R6 access to open row",
              {sd_open, dfi_bank, sd_row}, {1'b1, bus_adr[ADDR_W-1:COL_W]});
          if (c == C_WR) begin
            int k;
            k = key(dfi_bank, sd_row, dfi_addr[COL_W-1:0]);
            sd_mem[k] = merge(sd_mem.exists(k) ? sd_mem[k] : '0, dfi_wrdata, dfi_mask);
            last_rd = 1'b0;
          end else begin
            int k;
            k = key(dfi_bank, sd_row, dfi_addr[COL_W-1:0]);
            rd_val = sd_mem.exists(k) ? sd_mem[k] : '0;
            rd_cnt = CL; rd_cyc = cyc_n; last_rd = 1'b1;
          end
        end
        default: ;
      endcase
      if (bus_ack) begin
        if (last_rd) chk(cyc_n == rd_cyc + CL + 1, "R10 read ack timing", cyc_n, rd_cyc + CL + 1);
        else         chk(c == C_WR, "R11 write ack with command", c, C_WR);
      end
      if (c != C_NOP) begin
        last_cmd = c; last_cyc = cyc_n;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit we, input logic [ADDR_W-1:0] adr,
                        input logic [DATA_W-1:0] dat, input logic [SEL_W-1:0] sel,
                        input string tag);
    bit hit, was_open, got;
    int k;
    @(posedge clk); #2;
    bus_cyc = 1'b1; bus_we = we; bus_adr = adr; bus_dat = dat; bus_sel = sel;
    n_act = 0; n_pre = 0; n_ref = 0; pre_then_ref = 1'b0;
    was_open = exp_open;
    hit = exp_open && (exp_tag == adr[ADDR_W-1:COL_W]);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (bus_ack) begin got = 1'b1; break; end
    end
    chk(got, {tag, " R12 ack seen"}, got, 1);
    k = int'(adr);
    if (we) exp_mem[k] = merge(exp_mem.exists(k) ? exp_mem[k] : '0, dat, ~sel);
    else chk(bus_dat_o == (exp_mem.exists(k) ? exp_mem[k] : '0), {tag, " R10 read data"},
             bus_dat_o, exp_mem.exists(k) ? exp_mem[k] : '0);
    if (n_ref > 0) begin
      chk(n_ref == 1 && n_act == 1 && act_after_ref && n_pre <= 1,
          {tag, " R9 refresh before access"}, {n_ref, n_act, n_pre}, 1);
      if (pre_then_ref) col_cnt++;
    end else if (hit)
      chk(n_act == 0 && n_pre == 0, {tag, " R6 hit path"}, {n_act, n_pre}, 0);
    else if (was_open)
      chk(n_act == 1 && n_pre == 1, {tag, " R7 miss-open path"}, {n_act, n_pre}, {32'd1, 32'd1});
    else
      chk(n_act == 1 && n_pre == 0, {tag, " R7 miss-closed path"}, {n_act, n_pre}, {32'd1, 32'd0});
    exp_open = 1'b1;
    exp_tag = adr[ADDR_W-1:COL_W];
  endtask

  task automatic idle(input int n);
    @(posedge clk); #2;
    bus_cyc = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int b, input int r, input int c);
    return {BA_W'(b), ROW_W'(r), COL_W'(c)};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #2 rst_ni = 1'b1;
    idle(3);
    access(1'b1, mk(0, 1, 3), 32'hA5A5_1234, 4'hF, "dir wr closed");
    access(1'b0, mk(0, 1, 3), '0, 4'hF, "dir rd hit");
    access(1'b1, mk(0, 1, 4), 32'h1122_3344, 4'hF, "dir wr hit");
    access(1'b1, mk(0, 1, 4), 32'hFFEE_DDCC, 4'b0101, "dir R3 masked wr");
    access(1'b0, mk(0, 1, 4), '0, 4'h0, "dir R3 masked rd");
    access(1'b0, mk(0, 2, 4), '0, 4'hF, "dir rd miss row");
    access(1'b1, mk(1, 2, 4), 32'h0BAD_F00D, 4'hF, "dir wr miss bank");
    access(1'b0, mk(1, 2, 4), '0, 4'hF, "dir rd other bank");
    for (int i = 0; i < 700; i++) begin
      access($urandom % 2 == 0, mk($urandom % 2, $urandom % 3, $urandom % 8),
             DATA_W'($urandom), SEL_W'($urandom), "rand");
      if ($urandom % 8 == 0) idle($urandom % 4);
    end
    chk(col_cnt > 0, "R9 refresh/request collisions seen", col_cnt, 1);
    idle(2 * T_REFI + 20);
    chk(ref_k >= 2, "R8 refreshes while idle", ref_k, 2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule